// File: doc/BRIEF.md
# CPU Clock Rate-Change Sequencer

This block issues the register writes that keep a processor-domain clock safe while the PLL feeding it is reprogrammed. Two pulse inputs mark the moments before and after the PLL change. Each pulse comes with the old rate, the new rate and the rate of a fallback source, all as integer MHz. Before the change, the sequencer steers the core clock mux to the fallback source. When the fallback runs faster than the old rate, it also loads a temporary core divider in the same write, so the divided output never exceeds the old rate. After the change, it returns the mux to the PLL and clears the core divider. It also applies the auxiliary divider settings stored for the new rate, and the order of those writes follows the direction of the change.

Each register write uses a masked format. Bits 31:16 of the word enable the matching bits 15:0, so a write touches only the fields it names. The core register sits at address 0x044. Its mux select is bit 7, and the 5-bit core divider occupies bits 4:0. A divider value n divides the parent rate by n+1. An eight-entry table holds the supported target rates, and each entry has four auxiliary write slots. The table is loaded through a configuration port while the sequencer is idle. Each event ends with a one-cycle `done` pulse, or with an `err` pulse when the new rate has no table entry.

Top module: `cpuclk_seq`

## Requirements
- R1: After reset, `wr_en`, `busy`, `done` and `err` are all low.
- R2: On a pre-change event with alt_rate > old_rate, exactly one write goes to 0x044 with data {16'h009F, 16'h0080 | f}, where f = ceil(alt_rate/old_rate) - 1.
- R3: When f would exceed 31, it is clamped to 31. An old_rate of 0 with a nonzero alt_rate also gives 31.
- R4: On a pre-change event with alt_rate <= old_rate, exactly one write goes to 0x044 with data 32'h0080_0080, which selects the fallback source and leaves the divider unchanged.
- R5: On a post-change event whose new_rate matches no table rate, `err` pulses and no write is issued. A rate value of 0 never matches.
- R6: On a post-change event with new_rate > old_rate, the entry's auxiliary writes go out first, in slot order 0 to 3. They are followed by one write of 32'h009F_0000 to 0x044, which selects the PLL and clears the divider.
- R7: On a post-change event with new_rate < old_rate, the 32'h009F_0000 write to 0x044 goes out first, followed by the auxiliary writes in slot order.
- R8: On a post-change event with new_rate == old_rate, only the 32'h009F_0000 write to 0x044 is issued.
- R9: An auxiliary slot whose stored address is 0 produces no write.
- R10: While `busy` is high, new events and configuration writes have no effect. The running sequence completes unchanged, no extra sequence follows, and the table keeps its old contents.
- R11: Each event ends with exactly one single-cycle pulse of either `done` or `err`, never both at once.
- R12: When several entries hold the same rate, the entry with the lowest index supplies the auxiliary writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate_we | input | 1 | Load the rate of table entry `cfg_entry` |
| cfg_aux_we | input | 1 | Load auxiliary slot `cfg_slot` of entry `cfg_entry` |
| cfg_entry | input | 3 | Table entry index for configuration |
| cfg_slot | input | 2 | Auxiliary slot index for configuration |
| cfg_rate | input | 16 | Rate value in MHz |
| cfg_addr | input | 12 | Auxiliary write address (0 means the slot is unused) |
| cfg_data | input | 32 | Auxiliary write data |
| ev_pre | input | 1 | Pre-change event pulse |
| ev_post | input | 1 | Post-change event pulse (`ev_pre` wins if both are high) |
| old_rate | input | 16 | Rate before the change, in MHz |
| new_rate | input | 16 | Rate after the change, in MHz |
| alt_rate | input | 16 | Fallback source rate, in MHz |
| wr_en | output | 1 | Register write strobe, high for one cycle per write |
| wr_addr | output | 12 | Register write address |
| wr_data | output | 32 | Register write data, in the masked format |
| busy | output | 1 | An event is in progress |
| done | output | 1 | Event finished successfully |
| err | output | 1 | Post-change event found no matching rate |

## Verification
A wrong quotient in the divider shows up as a wrong low field in the single pre-change write. That write appears a fixed number of cycles after the event, so the error is visible within about twenty cycles. A wrong direction flag or slot counter shows up at the write port within the same event, as reordered, missing or extra writes. Corrupted latched rates or table contents show up as a misplaced `err` pulse or as wrong auxiliary data. Any event or configuration write that leaks through while the sequencer is busy appears as a stray write or a changed table, at the latest on the next event.

// File: rtl/cpuclk_seq_pkg.sv
package cpuclk_seq_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DIV,
      ST_PREWR,
      ST_LOOK,
      ST_AUX,
      ST_REMUX,
      ST_FIN
   } seq_st_t;
endpackage

// File: rtl/cpuclk_ceil_div.sv
module cpuclk_ceil_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start_i,
   input  logic [W:0]   num_i,
   input  logic [W-1:0] den_i,
   output logic         valid_o,
   output logic [W:0]   quo_o
);
   localparam int CNT_W = $clog2(W + 2);
   localparam logic [CNT_W-1:0] STEPS = CNT_W'(W + 1);

   logic [W:0]       num_q, q_q;
   logic [W-1:0]     den_q;
   logic [W+1:0]     rem_q, sh, diff;
   logic [CNT_W-1:0] cnt_q;
   logic             run_q, valid_q, take;

   assign sh   = {rem_q[W:0], q_q[W]};
   assign take = sh >= {2'b00, den_q};
   assign diff = sh - {2'b00, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_q   <= '0;
         q_q     <= '0;
         den_q   <= '0;
         rem_q   <= '0;
         cnt_q   <= '0;
         run_q   <= 1'b0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (start_i) begin
            num_q <= num_i;
            q_q   <= num_i;
            den_q <= den_i;
            rem_q <= '0;
            cnt_q <= STEPS;
            run_q <= 1'b1;
         end else if (run_q) begin
            rem_q <= take ? diff : sh;
            q_q   <= {q_q[W-1:0], take};
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNT_W'(1)) begin
               run_q   <= 1'b0;
               valid_q <= 1'b1;
            end
         end
      end
   end

   assign valid_o = valid_q;
   assign quo_o   = q_q;

   logic [2*W+1:0] prod_lo, prod_hi;
   assign prod_lo = (2*W+2)'(q_q) * (2*W+2)'(den_q);
   assign prod_hi = prod_lo + (2*W+2)'(den_q);

   // R2: the quotient brackets the dividend exactly
   p_quot_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && den_q != '0) |-> (prod_lo <= (2*W+2)'(num_q) && (2*W+2)'(num_q) < prod_hi));

   // R2: partial remainder stays below the divisor
   p_rem_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && den_q != '0) |-> rem_q < {2'b00, den_q});
endmodule

// File: rtl/cpuclk_rate_tbl.sv
module cpuclk_rate_tbl #(
   parameter int N_ENTRY = 8,
   parameter int N_AUX   = 4,
   parameter int RATE_W  = 16,
   parameter int ADDR_W  = 12,
   parameter int DATA_W  = 32
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       lock_i,
   input  logic                       rate_we_i,
   input  logic                       aux_we_i,
   input  logic [$clog2(N_ENTRY)-1:0] wr_entry_i,
   input  logic [$clog2(N_AUX)-1:0]   wr_slot_i,
   input  logic [RATE_W-1:0]          wr_rate_i,
   input  logic [ADDR_W-1:0]          wr_addr_i,
   input  logic [DATA_W-1:0]          wr_data_i,
   input  logic [RATE_W-1:0]          key_i,
   output logic                       hit_o,
   output logic [$clog2(N_ENTRY)-1:0] hit_idx_o,
   input  logic [$clog2(N_ENTRY)-1:0] rd_entry_i,
   input  logic [$clog2(N_AUX)-1:0]   rd_slot_i,
   output logic [ADDR_W-1:0]          rd_addr_o,
   output logic [DATA_W-1:0]          rd_data_o
);
   localparam int IDX_W = $clog2(N_ENTRY);

   logic [N_ENTRY-1:0][RATE_W-1:0]            rate_q;
   logic [N_ENTRY-1:0][N_AUX-1:0][ADDR_W-1:0] addr_q;
   logic [N_ENTRY-1:0][N_AUX-1:0][DATA_W-1:0] data_q;
   logic [N_ENTRY-1:0]                        match;

   for (genvar e = 0; e < N_ENTRY; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rate_q[e] <= '0;
            addr_q[e] <= '0;
            data_q[e] <= '0;
         end else if (!lock_i && wr_entry_i == IDX_W'(e)) begin
            if (rate_we_i)
               rate_q[e] <= wr_rate_i;
            if (aux_we_i) begin
               addr_q[e][wr_slot_i] <= wr_addr_i;
               data_q[e][wr_slot_i] <= wr_data_i;
            end
         end
      end
      assign match[e] = (rate_q[e] == key_i) && (rate_q[e] != '0);
   end

   // lowest index wins: scan downward so the last assignment is the lowest hit
   always_comb begin
      hit_idx_o = '0;
      for (int e = N_ENTRY - 1; e >= 0; e--)
         if (match[e])
            hit_idx_o = IDX_W'(e);
   end
   assign hit_o     = |match;
   assign rd_addr_o = addr_q[rd_entry_i][rd_slot_i];
   assign rd_data_o = data_q[rd_entry_i][rd_slot_i];

   // R10: table contents frozen while the sequencer runs
   p_table_locked_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lock_i |=> ($stable(rate_q) && $stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/cpuclk_seq.sv
module cpuclk_seq #(
   parameter int              N_ENTRY   = 8,
   parameter int              N_AUX     = 4,
   parameter int              RATE_W    = 16,
   parameter int              ADDR_W    = 12,
   parameter int              DATA_W    = 32,
   parameter int              DIV_W     = 5,
   parameter int              DIV_SHIFT = 0,
   parameter int              MUX_BIT   = 7,
   parameter logic [11:0]     CORE_ADDR = 12'h044
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_rate_we,
   input  logic                       cfg_aux_we,
   input  logic [$clog2(N_ENTRY)-1:0] cfg_entry,
   input  logic [$clog2(N_AUX)-1:0]   cfg_slot,
   input  logic [RATE_W-1:0]          cfg_rate,
   input  logic [ADDR_W-1:0]          cfg_addr,
   input  logic [DATA_W-1:0]          cfg_data,
   input  logic                       ev_pre,
   input  logic                       ev_post,
   input  logic [RATE_W-1:0]          old_rate,
   input  logic [RATE_W-1:0]          new_rate,
   input  logic [RATE_W-1:0]          alt_rate,
   output logic                       wr_en,
   output logic [ADDR_W-1:0]          wr_addr,
   output logic [DATA_W-1:0]          wr_data
   ,output logic                      busy,
   output logic                       done,
   output logic                       err
);
   import cpuclk_seq_pkg::*;

   localparam int IDX_W  = $clog2(N_ENTRY);
   localparam int SLOT_W = $clog2(N_AUX);
   localparam int HALF   = DATA_W / 2;
   localparam logic [HALF-1:0]   MUX_M   = HALF'(1) << MUX_BIT;
   localparam logic [HALF-1:0]   DIV_M   = HALF'((1 << DIV_W) - 1) << DIV_SHIFT;
   localparam logic [RATE_W:0]   DIV_MAX = (RATE_W+1)'((1 << DIV_W) - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_AUX - 1);

   if (DATA_W != 32 || N_ENTRY < 2 || N_AUX < 2) begin : g_bad_shape
      $error("cpuclk_seq: needs 32-bit masked data and at least two entries and slots");
   end
   if (DIV_SHIFT + DIV_W > HALF || MUX_BIT >= HALF ||
       (MUX_BIT >= DIV_SHIFT && MUX_BIT < DIV_SHIFT + DIV_W)) begin : g_bad_fields
      $error("cpuclk_seq: mux bit and divider field must fit and not overlap");
   end
   if (ADDR_W < 12) begin : g_bad_addr
      $error("cpuclk_seq: address too narrow for core register");
   end

   seq_st_t            st_q;
   logic [RATE_W-1:0]  old_q, new_q, alt_q;
   logic [IDX_W-1:0]   idx_q;
   logic [SLOT_W-1:0]  slot_q;
   logic [DIV_W-1:0]   divf_q;
   logic               aux_first_q, use_div_q, bad_q;

   logic               div_start, div_valid;
   logic [RATE_W:0]    div_quo, quo_m1;
   logic               hit;
   logic [IDX_W-1:0]   hit_idx;
   logic [ADDR_W-1:0]  aux_addr;
   logic [DATA_W-1:0]  aux_data;

   assign busy      = (st_q != ST_IDLE);
   assign div_start = (st_q == ST_IDLE) && ev_pre && (alt_rate > old_rate);
   assign quo_m1    = div_quo - 1'b1;

   cpuclk_ceil_div #(.W(RATE_W)) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (div_start),
      .num_i   ({1'b0, alt_rate} + {1'b0, old_rate} - 1'b1),
      .den_i   (old_rate),
      .valid_o (div_valid),
      .quo_o   (div_quo)
   );

   cpuclk_rate_tbl #(
      .N_ENTRY (N_ENTRY),
      .N_AUX   (N_AUX),
      .RATE_W  (RATE_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W)
   ) u_tbl (
      .clk        (clk),
      .rst_n      (rst_n),
      .lock_i     (busy),
      .rate_we_i  (cfg_rate_we),
      .aux_we_i   (cfg_aux_we),
      .wr_entry_i (cfg_entry),
      .wr_slot_i  (cfg_slot),
      .wr_rate_i  (cfg_rate),
      .wr_addr_i  (cfg_addr),
      .wr_data_i  (cfg_data),
      .key_i      (new_q),
      .hit_o      (hit),
      .hit_idx_o  (hit_idx),
      .rd_entry_i (idx_q),
      .rd_slot_i  (slot_q),
      .rd_addr_o  (aux_addr),
      .rd_data_o  (aux_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_IDLE;
         old_q       <= '0;
         new_q       <= '0;
         alt_q       <= '0;
         idx_q       <= '0;
         slot_q      <= '0;
         divf_q      <= '0;
         aux_first_q <= 1'b0;
         use_div_q   <= 1'b0;
         bad_q       <= 1'b0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               bad_q  <= 1'b0;
               slot_q <= '0;
               if (ev_pre || ev_post) begin
                  old_q <= old_rate;
                  new_q <= new_rate;
                  alt_q <= alt_rate;
               end
               if (ev_pre) begin
                  use_div_q <= 1'b0;
                  st_q      <= div_start ? ST_DIV : ST_PREWR;
               end else if (ev_post) begin
                  st_q <= ST_LOOK;
               end
            end
            ST_DIV: if (div_valid) begin
               divf_q    <= (quo_m1 > DIV_MAX) ? DIV_MAX[DIV_W-1:0] : quo_m1[DIV_W-1:0];
               use_div_q <= 1'b1;
               st_q      <= ST_PREWR;
            end
            ST_PREWR: st_q <= ST_FIN;
            ST_LOOK: begin
               idx_q       <= hit_idx;
               aux_first_q <= new_q > old_q;
               if (!hit) begin
                  bad_q <= 1'b1;
                  st_q  <= ST_FIN;
               end else begin
                  st_q <= (new_q > old_q) ? ST_AUX : ST_REMUX;
               end
            end
            ST_AUX: begin
               slot_q <= slot_q + 1'b1;
               if (slot_q == SLOT_LAST)
                  st_q <= aux_first_q ? ST_REMUX : ST_FIN;
            end
            ST_REMUX: st_q <= (!aux_first_q && new_q < old_q) ? ST_AUX : ST_FIN;
            default:  st_q <= ST_IDLE;
         endcase
      end
   end

   logic [HALF-1:0] en_h, val_h;
   always_comb begin
      en_h    = '0;
      val_h   = '0;
      wr_en   = 1'b0;
      wr_addr = ADDR_W'(CORE_ADDR);
      wr_data = '0;
      case (st_q)
         ST_PREWR: begin
            en_h  = MUX_M | (use_div_q ? DIV_M : '0);
            val_h = MUX_M | (use_div_q ? (HALF'(divf_q) << DIV_SHIFT) : '0);
            wr_en = 1'b1;
         end
         ST_REMUX: begin
            en_h  = MUX_M | DIV_M;
            wr_en = 1'b1;
         end
         default: ;
      endcase
      wr_data = {en_h, val_h};
      if (st_q == ST_AUX) begin
         wr_en   = aux_addr != '0;
         wr_addr = aux_addr;
         wr_data = aux_data;
      end
   end

   assign done = (st_q == ST_FIN) && !bad_q;
   assign err  = (st_q == ST_FIN) && bad_q;

   // R11: an event never reports both outcomes
   p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && err));

   // R11: outcome pulse lasts a single cycle
   p_pulse_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (done || err) |=> !(done || err));

   // R5: an unmatched rate finishes without a write just before
   p_err_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> !$past(wr_en));

   // R10: captured rates stay put for the whole sequence
   p_hold_rates_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(old_q) && $stable(new_q) && $stable(alt_q)));

   // R3: the alternate divider never leaves its field
   p_alt_field_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && st_q == ST_PREWR) |-> ((wr_data[HALF-1:0] & ~(MUX_M | DIV_M)) == '0));
endmodule

// File: tb/cpuclk_seq_bench.sv
`timescale 1ns/100ps
module cpuclk_seq_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_rate_we = 0, cfg_aux_we = 0;
   logic [2:0]  cfg_entry = 0;
   logic [1:0]  cfg_slot = 0;
   logic [15:0] cfg_rate = 0;
   logic [11:0] cfg_addr = 0;
   logic [31:0] cfg_data = 0;
   logic        ev_pre = 0, ev_post = 0;
   logic [15:0] old_rate = 0, new_rate = 0, alt_rate = 0;
   logic        wr_en, busy, done, err;
   logic [11:0] wr_addr;
   logic [31:0] wr_data;

   always #2.5 clk = ~clk;

   cpuclk_seq u_cpuclk_seq (
      .clk(clk), .rst_n(rst_n),
      .cfg_rate_we(cfg_rate_we), .cfg_aux_we(cfg_aux_we),
      .cfg_entry(cfg_entry), .cfg_slot(cfg_slot), .cfg_rate(cfg_rate),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .ev_pre(ev_pre), .ev_post(ev_post),
      .old_rate(old_rate), .new_rate(new_rate), .alt_rate(alt_rate),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done), .err(err)
   );

   int n_chk = 0, n_bad = 0;
   bit finished = 0;

   int          m_rate [8];
   logic [11:0] m_addr [8][4];
   logic [31:0] m_data [8][4];

   logic [11:0] ex_a [16];
   logic [31:0] ex_d [16];
   int          ex_n;
   bit          ex_err;
   logic [11:0] ca [16];
   logic [31:0] cd [16];
   int          cn;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pre_word(input int o, input int a);
      int q;
      if (a <= o) return 32'h0080_0080;
      if (o == 0) q = 32;
      else q = (a + o - 1) / o;
      if (q - 1 > 31) q = 32;
      return {16'h009F, 16'h0080 | 16'(q - 1)};
   endfunction

   task automatic cfg_rate_w(input int e, input int r);
      @(negedge clk);
      cfg_rate_we = 1; cfg_entry = 3'(e); cfg_rate = 16'(r);
      @(negedge clk);
      cfg_rate_we = 0;
      m_rate[e] = r;
   endtask

   task automatic cfg_aux_w(input int e, input int s, input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_aux_we = 1; cfg_entry = 3'(e); cfg_slot = 2'(s); cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_aux_we = 0;
      m_addr[e][s] = a; m_data[e][s] = d;
   endtask

   task automatic push(input logic [11:0] a, input logic [31:0] d);
      ex_a[ex_n] = a; ex_d[ex_n] = d; ex_n++;
   endtask

   task automatic build_post(input int o, input int n);
      int e;
      e = -1;
      ex_n = 0;
      for (int i = 7; i >= 0; i--)
         if (m_rate[i] == n && n != 0) e = i;
      ex_err = (e < 0);
      if (ex_err) return;
      if (n > o)
         for (int s = 0; s < 4; s++) if (m_addr[e][s] != 0) push(m_addr[e][s], m_data[e][s]);
      push(12'h044, 32'h009F_0000);
      if (n < o)
         for (int s = 0; s < 4; s++) if (m_addr[e][s] != 0) push(m_addr[e][s], m_data[e][s]);
   endtask

   task automatic run(input bit is_pre, input int o, input int n, input int a,
                      input bit disturb, input string tag);
      int  cyc;
      bit  gd, ge;
      int  stray;
      @(negedge clk);
      ev_pre = is_pre; ev_post = !is_pre;
      old_rate = 16'(o); new_rate = 16'(n); alt_rate = 16'(a);
      @(negedge clk);
      ev_pre = 0; ev_post = 0;
      cn = 0; cyc = 0;
      while (cyc < 200) begin
         if (wr_en && cn < 16) begin ca[cn] = wr_addr; cd[cn] = wr_data; cn++; end
         else if (wr_en) cn++;
         if (done || err) break;
         if (disturb && cyc == 1) begin
            ev_pre = 1; ev_post = 1; alt_rate = 16'd9000; new_rate = 16'd1234;
            cfg_rate_we = 1; cfg_entry = 3'd7; cfg_rate = 16'd1234;
            cfg_aux_we = 1; cfg_slot = 2'd0; cfg_addr = 12'h3FC; cfg_data = 32'hDEAD_BEEF;
         end
         if (disturb && cyc == 2) begin
            ev_pre = 0; ev_post = 0; cfg_rate_we = 0; cfg_aux_we = 0;
         end
         @(negedge clk);
         cyc++;
      end
      ev_pre = 0; ev_post = 0; cfg_rate_we = 0; cfg_aux_we = 0;
      gd = done; ge = err;
      @(negedge clk);
      chk(!done && !err, {tag, " R11 pulse width"}, {30'd0, done, err}, 32'd0);
      stray = 0;
      for (int k = 0; k < 4; k++) begin
         if (wr_en || busy) stray++;
         @(negedge clk);
      end
      chk(stray == 0, {tag, " R10 no trailing activity"}, 32'(stray), 32'd0);
      chk(ge == ex_err && gd == !ex_err, {tag, " R11 outcome"}, {30'd0, gd, ge}, {30'd0, !ex_err, ex_err});
      chk(cn == ex_n, {tag, " write count"}, 32'(cn), 32'(ex_n));
      for (int i = 0; i < ex_n && i < cn && i < 16; i++) begin
         chk(ca[i] == ex_a[i], {tag, " R9 addr"}, 32'(ca[i]), 32'(ex_a[i]));
         chk(cd[i] == ex_d[i], {tag, " data"}, cd[i], ex_d[i]);
      end
   endtask

   task automatic do_pre(input int o, input int a);
      string tag;
      int q;
      if (a <= o) tag = "R4";
      else begin
         q = (o == 0) ? 99 : (a + o - 1) / o;
         tag = (q - 1 > 31) ? "R3" : "R2";
      end
      ex_n = 0; ex_err = 0;
      push(12'h044, pre_word(o, a));
      run(1'b1, o, 0, a, 1'b0, tag);
   endtask

   task automatic do_post(input int o, input int n, input bit disturb);
      string tag;
      build_post(o, n);
      if (ex_err) tag = "R5";
      else if (n > o) tag = "R6";
      else if (n < o) tag = "R7";
      else tag = "R8";
      if (n == 600) tag = {tag, " R12"};
      run(1'b0, o, n, 0, disturb, tag);
   endtask

   initial begin
      void'($urandom(32'd2024));
      for (int e = 0; e < 8; e++) begin
         m_rate[e] = 0;
         for (int s = 0; s < 4; s++) begin m_addr[e][s] = 0; m_data[e][s] = 0; end
      end
      #1;
      chk(!wr_en && !busy && !done && !err, "R1 in reset", {28'd0, wr_en, busy, done, err}, 32'd0);
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!wr_en && !busy && !done && !err, "R1 after reset", {28'd0, wr_en, busy, done, err}, 32'd0);

      for (int e = 0; e < 8; e++) begin
         cfg_rate_w(e, (e == 6) ? 600 : 200 * (e + 1));
         for (int s = 0; s < 4; s++)
            cfg_aux_w(e, s, ((e + s) % 3 == 0) ? 12'h000 : 12'((e * 4 + s + 1) * 4), $urandom);
      end

      do_pre(300, 1000);   // R2: ceil 4 -> field 3
      do_pre(500, 501);    // R2: field 1
      do_pre(10, 5000);    // R3: clamp
      do_pre(0, 700);      // R3: zero old rate
      do_pre(800, 800);    // R4: equal
      do_pre(900, 100);    // R4: slower alt
      do_post(400, 999, 0); // R5
      do_post(400, 0, 0);   // R5
      do_post(400, 1000, 0); // R6
      do_post(1600, 800, 0); // R7
      do_post(1200, 1200, 0); // R8
      do_post(200, 600, 0);   // R12 duplicate entries
      do_post(200, 1600, 1);  // R10 disturbance while busy
      do_post(200, 1234, 0);  // R10: rate not loaded -> R5 error
      do_post(200, 1600, 0);  // R10: entry 7 unchanged

      for (int i = 0; i < 40; i++)
         do_pre($urandom_range(0, 1500), $urandom_range(1, 4000));
      for (int i = 0; i < 40; i++) begin
         int n;
         n = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 2000) : m_rate[$urandom_range(0, 7)];
         do_post($urandom_range(0, 3) == 0 ? n : $urandom_range(1, 2000), n, 0);
      end

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule